// File: doc/BRIEF.md
# Integer Arithmetic Unit with Condition Flags

This block is the arithmetic and logic stage of a small processor core. It takes two 32-bit operands and a 4-bit function code. It produces the combinational result of one of four operations in the same cycle: add, subtract, bitwise AND or bitwise XOR. It also keeps a 3-bit condition register that holds the zero, sign and overflow indications.

The operands are ordered so that subtraction yields the second operand minus the first. The surrounding datapath writes that result back to the register named by the second operand. The condition register loads on a clock edge only when the caller raises the flag-update enable with a valid function code. Function codes outside the four valid ones give a zero result and raise an invalid-function indication, and they never disturb the stored flags.

The design is built around a decode step that maps the code onto an enumerated operation with a unique case. A single process owns the condition register, and a separate process drives the outputs. Two named transitions act on the register: LOAD, taken when the enable is high and the code is valid, and HOLD in every other cycle.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 gives result = B + A, modulo 2^32.
- R2: Function code 1 gives result = B - A, modulo 2^32.
- R3: Function code 2 gives B AND A, and function code 3 gives B XOR A.
- R4: Any function code from 4 to 15 gives a result of zero and drives bad_func high. The stored flags keep their value even when flag_en is high. For codes 0 to 3, bad_func is low.
- R5: After a LOAD, flag_z is 1 exactly when the loaded result was all zeros, and flag_s equals bit 31 of that result.
- R6: After a LOAD of an add, flag_o is 1 exactly when A and B had equal sign bits and the result's sign bit differed from them.
- R7: After a LOAD of a subtract, flag_o is 1 exactly when A and B had different sign bits and the result's sign bit differed from B's.
- R8: After a LOAD of an AND or an XOR, flag_o is 0.
- R9: The flags load at the rising clock edge that follows a cycle with flag_en high and a valid code. When flag_en is low they hold, and the result output still follows the inputs.
- R10: While rst_n is low, the flags are forced at once to flag_z=1, flag_s=0 and flag_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 32 | First operand (the subtrahend for subtract) |
| opnd_b | input | 32 | Second operand |
| func | input | 4 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| flag_en | input | 1 | Load the condition register at the next edge |
| result | output | 32 | Combinational operation result |
| bad_func | output | 1 | High when func is above 3 |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored signed-overflow flag |

## Verification
Two functions meet in the same cycle: the result port shows the current operation, and the condition register captures the flags of that very result at the edge that closes the cycle. The bench provokes this by driving each vector at the falling edge. It judges the result just before the rising edge and the flags just after it, against values worked out from the requirements. It also runs an invalid code with the enable high in the same cycle. Here it must see a zero result together with flags that do not change. An AND that follows an overflowing subtract must clear the overflow flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic o;
    } cc_t;

    localparam cc_t CC_RESET = '{z: 1'b1, s: 1'b0, o: 1'b0};

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
#(
    parameter int FUNC_W = 4
) (
    input  logic [FUNC_W-1:0] func,
    output alu_op_e           op,
    output logic              valid
);

    localparam int OP_W = 2;

    generate
        if (FUNC_W > OP_W) begin : g_wide
            assign valid = (func[FUNC_W-1:OP_W] == '0);
        end else begin : g_narrow
            assign valid = 1'b1;
        end
    endgenerate

    always_comb begin
        unique case (func[OP_W-1:0])
            2'd0:    op = OP_ADD;
            2'd1:    op = OP_SUB;
            2'd2:    op = OP_AND;
            default: op = OP_XOR;
        endcase
    end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic           valid,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           ovf
);

    localparam int MSB = W - 1;

    logic          is_sub;
    logic [W-1:0]  addend;
    logic [W-1:0]  sum;

    // One adder serves both add and subtract: b + ~a + 1 = b - a
    assign is_sub = (op == OP_SUB);
    assign addend = is_sub ? ~a : a;
    assign sum    = b + addend + {{(W-1){1'b0}}, is_sub};

    always_comb begin
        res = '0;
        ovf = 1'b0;
        if (valid) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    res = sum;
                    ovf = (addend[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
                end
                OP_AND: res = b & a;
                OP_XOR: res = b ^ a;
            endcase
        end
    end

endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         ovf,
    output cc_t          cc_next
);

    always_comb begin
        cc_next.z = (res == '0);
        cc_next.s = res[W-1];
        cc_next.o = ovf;
    end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_pkg::*;
#(
    parameter int W      = 32,
    parameter int FUNC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [FUNC_W-1:0] func,
    input  logic              flag_en,
    output logic [W-1:0]      result,
    output logic              bad_func,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_o
);

    typedef enum logic {CC_HOLD, CC_LOAD} cc_act_e;

    alu_op_e      op;
    logic         op_valid;
    logic [W-1:0] dp_res;
    logic         dp_ovf;
    cc_t          cc_next;
    cc_t          cc_q;
    cc_act_e      act;

    alu_op_decode #(.FUNC_W(FUNC_W)) u_dec (
        .func  (func),
        .op    (op),
        .valid (op_valid)
    );

    alu_datapath #(.W(W)) u_dp (
        .op    (op),
        .valid (op_valid),
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (dp_res),
        .ovf   (dp_ovf)
    );

    alu_flag_calc #(.W(W)) u_fc (
        .res     (dp_res),
        .ovf     (dp_ovf),
        .cc_next (cc_next)
    );

    assign act = (flag_en && op_valid) ? CC_LOAD : CC_HOLD;

    // Condition register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q <= CC_RESET;
        end else begin
            unique case (act)
                CC_LOAD: cc_q <= cc_next;
                CC_HOLD: cc_q <= cc_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        result   = dp_res;
        bad_func = !op_valid;
        flag_z   = cc_q.z;
        flag_s   = cc_q.s;
        flag_o   = cc_q.o;
    end

    a_r4_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (func > 4'd3) |-> (result == '0 && bad_func));

    a_r4_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bad_func |=> $stable({flag_z, flag_s, flag_o}));

    a_r9_no_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable({flag_z, flag_s, flag_o}));

    a_r5_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && !bad_func) |=>
            (flag_z == ($past(result) == '0)) && (flag_s == $past(result[W-1])));

    a_r6_add_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && func == 4'd0 && opnd_a[W-1] == opnd_b[W-1]
            && result[W-1] != opnd_b[W-1]) |=> flag_o);

    a_r7_sub_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && func == 4'd1 && opnd_a[W-1] != opnd_b[W-1]
            && result[W-1] != opnd_b[W-1]) |=> flag_o);

    a_r8_logic_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && (func == 4'd2 || func == 4'd3)) |=> !flag_o);

endmodule

// File: tb/alu_cc_unit_test.sv
`timescale 1ns/1ps
module alu_cc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  func = '0;
    logic        flag_en = 1'b0;
    logic [31:0] result;
    logic        bad_func;
    logic        flag_z, flag_s, flag_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    alu_cc_unit uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .func(func), .flag_en(flag_en), .result(result), .bad_func(bad_func),
        .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
    );

    // {func, a, b, expected result, expected z s o}
    localparam int NV = 13;
    localparam logic [102:0] VEC [NV] = '{
        {4'h0, 32'h00000001, 32'h00000002, 32'h00000003, 3'b000}, // R1
        {4'h0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 3'b011}, // R1 R6
        {4'h0, 32'h80000000, 32'h80000000, 32'h00000000, 3'b101}, // R1 R6
        {4'h0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 3'b100}, // R1 R5
        {4'h1, 32'h00000001, 32'h00000005, 32'h00000004, 3'b000}, // R2
        {4'h1, 32'h00000005, 32'h00000001, 32'hFFFFFFFC, 3'b010}, // R2 R5
        {4'h1, 32'h00000001, 32'h80000000, 32'h7FFFFFFF, 3'b001}, // R2 R7
        {4'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 3'b011}, // R2 R7
        {4'h2, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 3'b010}, // R3 R8
        {4'h1, 32'h00000003, 32'h00000003, 32'h00000000, 3'b100}, // R2 R5
        {4'h2, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h00000000, 3'b100}, // R3
        {4'h3, 32'hFFFF0000, 32'h0FF00FF0, 32'hF00F0FF0, 3'b010}, // R3
        {4'h3, 32'h12345678, 32'h12345678, 32'h00000000, 3'b100}  // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic en);
        @(negedge clk);
        func = f; opnd_a = a; opnd_b = b; flag_en = en;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] cc();
        return {29'd0, flag_z, flag_s, flag_o};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        #3;
        chk("R10 reset flags", cc(), 32'b100);
        chk("R4 bad_func low for code 0", {31'd0, bad_func}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][102:99], VEC[i][98:67], VEC[i][66:35], 1'b1);
            #1;
            chk($sformatf("R1/R2/R3 result vec %0d", i), result, VEC[i][34:3]);
            chk($sformatf("R4 bad_func low vec %0d", i), {31'd0, bad_func}, 32'd0);
            after_edge();
            chk($sformatf("R5/R6/R7/R8 flags vec %0d", i), cc(), {29'd0, VEC[i][2:0]});
        end
        // flags now z=1 s=0 o=0

        // R9: enable low, result live, flags held
        drive(4'h0, 32'h7FFFFFFF, 32'h00000001, 1'b0);
        #1;
        chk("R9 result with enable low", result, 32'h80000000);
        after_edge();
        chk("R9 flags hold with enable low", cc(), 32'b100);

        // Same op with enable: flags load z0 s1 o1
        drive(4'h0, 32'h7FFFFFFF, 32'h00000001, 1'b1);
        after_edge();
        chk("R6 add overflow loaded", cc(), 32'b011);

        // R4: invalid codes with enable high
        for (int f = 4; f < 16; f++) begin
            drive(f[3:0], 32'h00000001, 32'h00000001, 1'b1);
            #1;
            chk($sformatf("R4 zero result code %0d", f), result, 32'h0);
            chk($sformatf("R4 bad_func code %0d", f), {31'd0, bad_func}, 32'd1);
            after_edge();
            chk($sformatf("R4 flags unchanged code %0d", f), cc(), 32'b011);
        end

        // R10: asynchronous reset mid-run
        drive(4'h2, 32'h0, 32'h0, 1'b0);
        #1;
        rst_n = 1'b0;
        #0.5;
        chk("R10 async reset flags", cc(), 32'b100);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule